// File: doc/BRIEF.md
# UART Interrupt Status Unit

This unit gathers fourteen event sources of a serial port into one sticky status register and raises a single active-high interrupt line while any source that software has enabled is pending. Sources arrive as one-cycle pulses or as held levels from the FIFOs and the line engine. The one exception is the clear-to-send input, which the unit watches itself and flags on every change of level.

Software reads either register through a small register port. It acknowledges events by writing ones to the status register, and it selects which sources may interrupt by writing the enable register. Two extra outputs report whether the pending, enabled sources include any from the receive group or from the transmit group. A handler can use them to decide which path to service first.

Top module: `uirq_unit`

## Requirements
- R1: Status bit positions are: 0 transmit holding empty, 1 receive holding full, 2 transmit FIFO low, 3 transmit FIFO empty, 4 receive FIFO high, 5 receive FIFO full, 6 transmit underrun, 7 receive overrun, 8 parity fault, 9 framing fault, 10 clear-to-send changed, 11 receive idle timeout, 12 break finished, 13 bus fault. An `evt_i` bit that is high at a rising clock edge sets the matching status bit, and the bit reads back as 1 from the next cycle on.
- R2: Status bits are set whatever the enable register holds. The enable register only gates the interrupt outputs.
- R3: A write with `wr_addr_i`=0 clears every status bit whose data bit is 1. Status bits written with 0 keep their value.
- R4: When an event and a clear of the same bit fall in the same cycle, the bit stays set.
- R5: A write with `wr_addr_i`=1 loads the enable register. `rd_data_o` shows the status register when `rd_addr_i`=0 and the enable register when `rd_addr_i`=1.
- R6: `irq_o` is high exactly when some status bit and its enable bit are both 1. It follows register updates in the cycle after the clock edge.
- R7: Every change of level on `cts_i`, rising or falling, sets status bit 10 at the next clock edge.
- R8: `evt_i[10]` has no effect on the status register.
- R9: `rx_irq_o` is high when an enabled pending bit lies among bits 4, 5, 7, 8, 9 and 11. `tx_irq_o` is high when one lies among bits 2, 3 and 6. Bits 0, 1, 10, 12 and 13 drive neither output.
- R10: After reset the status and enable registers are zero and all three interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 14 | Event pulses or levels, one per status bit |
| cts_i | input | 1 | Clear-to-send line level |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Write target: 0 status (write-one-to-clear), 1 enable |
| wr_data_i | input | 14 | Write data |
| rd_addr_i | input | 1 | Read select: 0 status, 1 enable |
| rd_data_o | output | 14 | Selected register contents |
| irq_o | output | 1 | Interrupt request, active high |
| rx_irq_o | output | 1 | Enabled receive-group event pending |
| tx_irq_o | output | 1 | Enabled transmit-group event pending |

## Verification
The bench sends an event into the same cycle as a write-one-to-clear of that bit. A design that lets the clear win would lose the event and report a status bit of 0. It walks every source with the enable register at zero, so a unit that set status only for enabled sources, or that put a source in the wrong position, shows up in the read-back. It toggles clear-to-send in both directions and pulses the raw bit 10 input. This catches a detector that sees only rising edges, and one that lets the plain event input through. Finally it sets sources from each group with everything enabled, so a source sorted into the wrong group reaches the wrong group output.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

  localparam int SRC_W = 14;

  localparam int SRC_TX_HOLD_EMPTY = 0;
  localparam int SRC_RX_HOLD_FULL  = 1;
  localparam int SRC_TXF_LOW       = 2;
  localparam int SRC_TXF_EMPTY     = 3;
  localparam int SRC_RXF_HIGH      = 4;
  localparam int SRC_RXF_FULL      = 5;
  localparam int SRC_TX_UNDER      = 6;
  localparam int SRC_RX_OVER       = 7;
  localparam int SRC_PARITY        = 8;
  localparam int SRC_FRAMING       = 9;
  localparam int SRC_CTS_CHG       = 10;
  localparam int SRC_RX_IDLE       = 11;
  localparam int SRC_BRK_END       = 12;
  localparam int SRC_BUS_FAULT     = 13;

  typedef logic [SRC_W-1:0] src_vec_t;

  localparam src_vec_t CTS_BIT = src_vec_t'(1 << SRC_CTS_CHG);

  localparam src_vec_t RX_GROUP = src_vec_t'((1 << SRC_RXF_HIGH) | (1 << SRC_RXF_FULL) |
                                             (1 << SRC_RX_OVER)  | (1 << SRC_PARITY)   |
                                             (1 << SRC_FRAMING)  | (1 << SRC_RX_IDLE));

  localparam src_vec_t TX_GROUP = src_vec_t'((1 << SRC_TXF_LOW) | (1 << SRC_TXF_EMPTY) |
                                             (1 << SRC_TX_UNDER));

  typedef enum logic {
    REG_STATUS = 1'b0,
    REG_ENABLE = 1'b1
  } reg_sel_e;

  // Sticky update: a set overrides a clear of the same bit.
  function automatic src_vec_t next_status(src_vec_t cur, src_vec_t clr, src_vec_t set);
    return set | (cur & ~clr);
  endfunction

  // Any bit pending and enabled inside a group mask.
  function automatic logic any_hit(src_vec_t st, src_vec_t en, src_vec_t grp);
    return |(st & en & grp);
  endfunction

endpackage

// File: rtl/uirq_cts_edge.sv
module uirq_cts_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cts_i,
  output logic toggle_o
);

  logic cts_q;
  logic primed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cts_q    <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      cts_q    <= cts_i;
      primed_q <= 1'b1;
    end
  end

  // Either direction of change counts once the reference is captured.
  assign toggle_o = primed_q & (cts_i ^ cts_q);

endmodule

// File: rtl/uirq_status_bank.sv
module uirq_status_bank
  import uirq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  src_vec_t set_i,
  input  src_vec_t clr_i,
  output src_vec_t status_o
);

  src_vec_t status_q;

  for (genvar k = 0; k < SRC_W; k++) begin : g_bit
    src_vec_t nxt;
    assign nxt = next_status(status_q, clr_i, set_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) status_q[k] <= 1'b0;
      else         status_q[k] <= nxt[k];
    end

    p_event_sets_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] |=> status_q[k]);

    p_set_beats_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i[k] && clr_i[k]) |=> status_q[k]);

    p_clear_drops_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[k] && !set_i[k]) |=> !status_q[k]);

    p_idle_holds_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i[k] && !set_i[k]) |=> $stable(status_q[k]));
  end

  assign status_o = status_q;

endmodule

// File: rtl/uirq_regs.sv
module uirq_regs
  import uirq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_en_i,
  input  logic     wr_addr_i,
  input  src_vec_t wr_data_i,
  input  logic     rd_addr_i,
  input  src_vec_t status_i,
  output src_vec_t enable_o,
  output src_vec_t clr_o,
  output src_vec_t rd_data_o
);

  src_vec_t enable_q;
  logic     wr_status;
  logic     wr_enable;

  assign wr_status = wr_en_i && (reg_sel_e'(wr_addr_i) == REG_STATUS);
  assign wr_enable = wr_en_i && (reg_sel_e'(wr_addr_i) == REG_ENABLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        enable_q <= '0;
    else if (wr_enable) enable_q <= wr_data_i;
  end

  assign clr_o     = wr_status ? wr_data_i : '0;
  assign enable_o  = enable_q;
  assign rd_data_o = (reg_sel_e'(rd_addr_i) == REG_ENABLE) ? enable_q : status_i;

  p_enable_loads_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_enable |=> (enable_q == $past(wr_data_i)));

  p_enable_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_enable |=> $stable(enable_q));

endmodule

// File: rtl/uirq_irq_gen.sv
module uirq_irq_gen
  import uirq_pkg::*;
(
  input  src_vec_t status_i,
  input  src_vec_t enable_i,
  output logic     irq_o,
  output logic     rx_irq_o,
  output logic     tx_irq_o
);

  localparam src_vec_t ALL_SRC = '1;

  assign irq_o    = any_hit(status_i, enable_i, ALL_SRC);
  assign rx_irq_o = any_hit(status_i, enable_i, RX_GROUP);
  assign tx_irq_o = any_hit(status_i, enable_i, TX_GROUP);

endmodule

// File: rtl/uirq_unit.sv
module uirq_unit
  import uirq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SRC_W-1:0]  evt_i,
  input  logic              cts_i,
  input  logic              wr_en_i,
  input  logic              wr_addr_i,
  input  logic [SRC_W-1:0]  wr_data_i,
  input  logic              rd_addr_i,
  output logic [SRC_W-1:0]  rd_data_o,
  output logic              irq_o,
  output logic              rx_irq_o,
  output logic              tx_irq_o
);

  logic     cts_toggle;
  src_vec_t set_vec;
  src_vec_t clr_vec;
  src_vec_t status_q;
  src_vec_t enable_q;

  uirq_cts_edge u_cts (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cts_i    (cts_i),
    .toggle_o (cts_toggle)
  );

  // The CTS position is fed only by the edge detector.
  assign set_vec = (evt_i & ~CTS_BIT) | (cts_toggle ? CTS_BIT : '0);

  uirq_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .status_i  (status_q),
    .enable_o  (enable_q),
    .clr_o     (clr_vec),
    .rd_data_o (rd_data_o)
  );

  uirq_status_bank u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_vec),
    .clr_i    (clr_vec),
    .status_o (status_q)
  );

  uirq_irq_gen u_irq (
    .status_i (status_q),
    .enable_i (enable_q),
    .irq_o    (irq_o),
    .rx_irq_o (rx_irq_o),
    .tx_irq_o (tx_irq_o)
  );

  p_cts_change_flags_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cts_toggle |=> status_q[SRC_CTS_CHG]);

  p_raw_cts_evt_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i[SRC_CTS_CHG] && !cts_toggle && !status_q[SRC_CTS_CHG]) |=> !status_q[SRC_CTS_CHG]);

  p_mask_zero_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i && (wr_data_i == '0)) |=> !irq_o);

  p_groups_within_irq_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_irq_o || tx_irq_o) |-> irq_o);

  p_reset_quiet_r10: assert property (@(posedge clk_i)
    !rst_ni |-> (!irq_o && status_q == '0));

endmodule

// File: tb/uirq_unit_bench.sv
module uirq_unit_bench;
  import uirq_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] evt = '0;
  logic        cts_in = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [13:0] wr_data = '0;
  logic        rd_addr = 1'b0;
  logic [13:0] rd_data;
  logic        irq, rx_irq, tx_irq;

  always #5 clk = ~clk;

  uirq_unit u_uirq_unit (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .cts_i(cts_in),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .irq_o(irq), .rx_irq_o(rx_irq), .tx_irq_o(tx_irq)
  );

  localparam logic [13:0] RXM = 14'h0BB0;
  localparam logic [13:0] TXM = 14'h004C;

  int checks = 0;
  int errors = 0;
  logic [30:0] exp_q[$];
  string       tag_q[$];
  logic [13:0] m_stat = '0;
  logic [13:0] m_en = '0;
  logic        m_cts = 1'b0;

  task automatic compare(input logic [30:0] act, input logic [30:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual stat=%h en=%h irq/rx/tx=%b expected stat=%h en=%h irq/rx/tx=%b",
               tag, act[30:17], act[16:3], act[2:0], exp[30:17], exp[16:3], exp[2:0]);
    end
  endtask

  task automatic sample(output logic [30:0] act);
    logic [13:0] s;
    rd_addr = 1'b0; #1; s = rd_data;
    rd_addr = 1'b1; #1;
    act = {s, rd_data, irq, rx_irq, tx_irq};
  endtask

  task automatic step(input logic [13:0] ev, input logic cts, input logic we,
                      input logic adr, input logic [13:0] data, input string tag);
    logic [13:0] nxt;
    @(negedge clk);
    evt = ev; cts_in = cts; wr_en = we; wr_addr = adr; wr_data = data;
    for (int b = 0; b < 14; b++) begin
      logic hit;
      hit = (b == 10) ? (cts != m_cts) : ev[b];
      if (hit)                          nxt[b] = 1'b1;
      else if (we && !adr && data[b])   nxt[b] = 1'b0;
      else                              nxt[b] = m_stat[b];
    end
    m_stat = nxt;
    m_cts = cts;
    if (we && adr) m_en = data;
    exp_q.push_back({m_stat, m_en, (m_stat & m_en) != 0,
                     (m_stat & m_en & RXM) != 0, (m_stat & m_en & TXM) != 0});
    tag_q.push_back(tag);
  endtask

  task automatic idle(input string tag);
    step('0, m_cts, 1'b0, 1'b0, '0, tag);
  endtask

  // Monitor: checks the reset state, then compares one queued item per cycle.
  initial begin
    logic [30:0] act;
    #12;
    sample(act);
    compare(act, '0, "R10");
    forever begin
      @(posedge clk); #2;
      if (exp_q.size() > 0) begin
        logic [30:0] exp;
        string t;
        exp = exp_q.pop_front();
        t = tag_q.pop_front();
        sample(act);
        compare(act, exp, t);
      end
    end
  end

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    idle("R10");
    // R1 / R2: every position with enable at zero, then R3 clear
    for (int i = 0; i < 14; i++) begin
      if (i != 10) begin
        step(14'(1 << i), m_cts, 1'b0, 1'b0, '0, "R1");
        idle("R2");
        step('0, m_cts, 1'b1, 1'b0, 14'(1 << i), "R3");
      end
    end
    // R8: raw CTS position ignored
    step(14'h0400, m_cts, 1'b0, 1'b0, '0, "R8");
    idle("R8");
    // R7: both directions
    step('0, 1'b1, 1'b0, 1'b0, '0, "R7");
    step('0, 1'b1, 1'b1, 1'b0, 14'h0400, "R7");
    step('0, 1'b0, 1'b0, 1'b0, '0, "R7");
    step('0, 1'b0, 1'b1, 1'b0, 14'h0400, "R7");
    // R3: partial clear leaves others
    step(14'h2A81, m_cts, 1'b0, 1'b0, '0, "R1");
    step('0, m_cts, 1'b1, 1'b0, 14'h0281, "R3");
    step('0, m_cts, 1'b1, 1'b0, 14'h3FFF, "R3");
    // R4: set and clear in the same cycle
    step(14'h0040, m_cts, 1'b0, 1'b0, '0, "R4");
    step(14'h0020, m_cts, 1'b1, 1'b0, 14'h0060, "R4");
    idle("R4");
    step('0, m_cts, 1'b1, 1'b0, 14'h3FFF, "R3");
    // R5 / R6
    step('0, m_cts, 1'b1, 1'b1, 14'h1234, "R5");
    step('0, m_cts, 1'b1, 1'b1, 14'h0001, "R5");
    step(14'h0002, m_cts, 1'b0, 1'b0, '0, "R6");
    step(14'h0001, m_cts, 1'b0, 1'b0, '0, "R6");
    step('0, m_cts, 1'b1, 1'b1, 14'h0000, "R6");
    step('0, m_cts, 1'b1, 1'b0, 14'h3FFF, "R3");
    // R9: group outputs with everything enabled
    step('0, m_cts, 1'b1, 1'b1, 14'h3FFF, "R5");
    step(14'h1000, m_cts, 1'b0, 1'b0, '0, "R9");
    step(14'h0010, m_cts, 1'b0, 1'b0, '0, "R9");
    step(14'h0004, m_cts, 1'b0, 1'b0, '0, "R9");
    step('0, m_cts, 1'b1, 1'b0, 14'h0010, "R9");
    step('0, m_cts, 1'b1, 1'b0, 14'h1004, "R9");
    step(14'h0800, m_cts, 1'b0, 1'b0, '0, "R9");
    step(14'h0008, 1'b1, 1'b0, 1'b0, '0, "R9");
    idle("R9");
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule